// File: doc/BRIEF.md
# USB Bus Event Flag and Mask Registers

This block holds the bus-level event flags of a USB device controller, together with a per-flag mask. Both are byte-wide registers on a simple register bus. The serial interface engine sends one-cycle pulses when any of these occur:

- a bus reset
- a resume while the device is suspended
- high-speed signalling from the host
- a bulk-endpoint token whose direction disagrees with the endpoint's configured direction

Each pulse sets a sticky flag. Software clears a flag by writing one to it. One more flag is not stored here: it follows a level from the separate error register and is read-only.

Flags whose mask bit is zero are ORed together. That OR feeds a latched summary bit, which a top-level interrupt register presents to the CPU. The summary latch is cleared from that top-level register through a dedicated clear input. The masks only gate the summary, so a masked event is still recorded in its flag.

Top module: `usb_evt_flags`

## Requirements
- R1: After reset the flag register reads 0x00, the mask register reads 0xFF and `irq_latched` is 0.
- R2: Flag bit 6 sets when `tok_out_ep` pulses while `ep_dir_in`=1, or when `tok_in_ep` pulses while `ep_dir_in`=0. A token that agrees with `ep_dir_in` leaves it clear.
- R3: A pulse on `hs_seen` sets flag bit 5, and a pulse on `bus_reset_seen` sets flag bit 3. Each flag is visible at the read port after the clock edge that takes the pulse.
- R4: A pulse on `resume_seen` sets flag bit 4 only while `suspended`=1. While `suspended`=0 the pulse is dropped.
- R5: Flag bit 2 reads as the current level of `err_pending`. Writing 1 to it has no effect.
- R6: Writing 1 to flag bits 6, 5, 4 or 3 clears them at the write edge. Writing 0 leaves them unchanged.
- R7: If an event pulse and a write-one-to-clear reach the same flag on the same edge, the flag is set after that edge.
- R8: Flag bits 7, 1 and 0 always read 0. Mask bits 7, 1 and 0 always read 1, whatever is written.
- R9: Mask bits 6..2 are read/write. A mask bit of 1 never stops its flag from being set.
- R10: `irq_latched` rises one edge after any flag with a 0 mask bit reads as 1. It is still 0 at the read taken just after the edge that made that flag visible.
- R11: `irq_latched` stays at 1 until an `irq_clr` pulse arrives while no unmasked flag is set. An `irq_clr` that arrives while an unmasked flag is set leaves it at 1.
- R12: The flag register is at offset `STAT_OFS` and the mask register at offset `MASK_OFS`. Any other offset reads 0x00, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register offset for read and write |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| tok_in_ep | input | 1 | Pulse: IN token addressed to the bulk endpoint |
| tok_out_ep | input | 1 | Pulse: OUT token addressed to the bulk endpoint |
| ep_dir_in | input | 1 | Level: 1 when the bulk endpoint is configured to send to the host |
| hs_seen | input | 1 | Pulse: high-speed signalling from the host |
| resume_seen | input | 1 | Pulse: resume signalling on the bus |
| bus_reset_seen | input | 1 | Pulse: bus reset on the bus |
| suspended | input | 1 | Level: device is in suspend |
| err_pending | input | 1 | Level: the separate error register is nonzero |
| irq_clr | input | 1 | Pulse: clear request for the summary latch |
| irq_latched | output | 1 | Latched summary interrupt |

## Verification
The bench counts edges from each stimulus to the result it should produce:

- **Flag bits 6..3** change at the edge that takes the event or the write, so the first read after that edge must show the change.
- **Flag bit 2 and the read mux** are combinational, so they follow `err_pending` and `reg_addr` within the same cycle.
- **The summary latch** lags the flag it depends on by one edge.

Each check is queued by the driver shortly after a rising edge. The monitor compares it a few nanoseconds later, so every comparison sees the state left by exactly the preceding edge. For R10 and R11 the bench uses back-to-back checks: one just after the flag appears, expecting the summary still low, and one after the following edge.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;

   localparam int REG_W = 8;

   // flag positions decoded by software and by the summary logic
   localparam int B_DIRERR = 6;
   localparam int B_HSHOST = 5;
   localparam int B_RESUME = 4;
   localparam int B_BUSRST = 3;
   localparam int B_ERRSUM = 2;

   localparam logic [REG_W-1:0] W1C_BITS  = 8'b0111_1000;
   localparam logic [REG_W-1:0] MIRR_BITS = 8'b0000_0100;
   localparam logic [REG_W-1:0] RSVD_BITS = 8'b1000_0011;

   typedef enum logic [1:0] {
      CELL_STICKY = 2'd0,
      CELL_MIRROR = 2'd1,
      CELL_ZERO   = 2'd2
   } cell_kind_e;

   function automatic cell_kind_e kind_of(input int pos);
      if (W1C_BITS[pos])       return CELL_STICKY;
      else if (MIRR_BITS[pos]) return CELL_MIRROR;
      else                     return CELL_ZERO;
   endfunction

endpackage

// File: rtl/usb_evt_detect.sv
module usb_evt_detect
   import usb_evt_pkg::*;
(
   input  logic             tok_in_ep,
   input  logic             tok_out_ep,
   input  logic             ep_dir_in,
   input  logic             hs_seen,
   input  logic             resume_seen,
   input  logic             bus_reset_seen,
   input  logic             suspended,
   output logic [REG_W-1:0] set_vec
);

   logic wrong_dir;

   // a token disagreeing with the configured direction of the bulk endpoint
   assign wrong_dir = (tok_out_ep & ep_dir_in) | (tok_in_ep & ~ep_dir_in);

   always_comb begin
      set_vec           = '0;
      set_vec[B_DIRERR] = wrong_dir;
      set_vec[B_HSHOST] = hs_seen;
      set_vec[B_RESUME] = resume_seen & suspended;
      set_vec[B_BUSRST] = bus_reset_seen;
   end

endmodule

// File: rtl/usb_evt_status.sv
module usb_evt_status
   import usb_evt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] set_vec,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   input  logic             err_lvl,
   output logic [REG_W-1:0] stat_q
);

   for (genvar i = 0; i < REG_W; i++) begin : g_cell
      localparam cell_kind_e KIND = kind_of(i);
      if (KIND == CELL_STICKY) begin : g_sticky
         logic flag_q;
         logic clr_hit;
         assign clr_hit = wr_en & wdata[i];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= set_vec[i] | (flag_q & ~clr_hit);
         end
         assign stat_q[i] = flag_q;
      end else if (KIND == CELL_MIRROR) begin : g_mirror
         assign stat_q[i] = err_lvl;
      end else begin : g_zero
         assign stat_q[i] = 1'b0;
      end
   end

   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|(set_vec & W1C_BITS)) |=> ((stat_q & $past(set_vec & W1C_BITS)) == $past(set_vec & W1C_BITS))); // R7

   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((stat_q & $past(wdata & W1C_BITS & ~set_vec)) == '0)); // R6

endmodule

// File: rtl/usb_evt_mask.sv
module usb_evt_mask
   import usb_evt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] mask_q
);

   logic [REG_W-1:0] store_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     store_q <= '1;
      else if (wr_en) store_q <= wdata;
   end

   // reserved positions are forced to one so they never contribute
   assign mask_q = store_q | RSVD_BITS;

endmodule

// File: rtl/usb_evt_summary.sv
module usb_evt_summary
   import usb_evt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] stat,
   input  logic [REG_W-1:0] mask,
   input  logic             clr,
   output logic             irq
);

   logic any_live;

   assign any_live = |(stat & ~mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= any_live | (irq & ~clr);
   end

   AST_IRQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      any_live |=> irq); // R10

   AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr) |=> irq); // R11

endmodule

// File: rtl/usb_evt_flags.sv
module usb_evt_flags
   import usb_evt_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int STAT_OFS = 16,
   parameter int MASK_OFS = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              tok_in_ep,
   input  logic              tok_out_ep,
   input  logic              ep_dir_in,
   input  logic              hs_seen,
   input  logic              resume_seen,
   input  logic              bus_reset_seen,
   input  logic              suspended,
   input  logic              err_pending,
   input  logic              irq_clr,
   output logic              irq_latched
);

   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
   localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);

   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_aw
      $error("usb_evt_flags: ADDR_W must be 1..16");
   end
   if (STAT_OFS < 0 || STAT_OFS >= (1 << ADDR_W) ||
       MASK_OFS < 0 || MASK_OFS >= (1 << ADDR_W)) begin : g_bad_ofs
      $error("usb_evt_flags: offsets must fit in ADDR_W bits");
   end
   if (STAT_OFS == MASK_OFS) begin : g_same_ofs
      $error("usb_evt_flags: register offsets must differ");
   end

   logic             sel_stat;
   logic             sel_mask;
   logic [REG_W-1:0] set_vec;
   logic [REG_W-1:0] stat_q;
   logic [REG_W-1:0] mask_q;

   assign sel_stat = (reg_addr == STAT_A);
   assign sel_mask = (reg_addr == MASK_A);

   usb_evt_detect i_detect (
      .tok_in_ep      (tok_in_ep),
      .tok_out_ep     (tok_out_ep),
      .ep_dir_in      (ep_dir_in),
      .hs_seen        (hs_seen),
      .resume_seen    (resume_seen),
      .bus_reset_seen (bus_reset_seen),
      .suspended      (suspended),
      .set_vec        (set_vec)
   );

   usb_evt_status i_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .wr_en   (reg_wr & sel_stat),
      .wdata   (reg_wdata),
      .err_lvl (err_pending),
      .stat_q  (stat_q)
   );

   usb_evt_mask i_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (reg_wr & sel_mask),
      .wdata  (reg_wdata),
      .mask_q (mask_q)
   );

   usb_evt_summary i_summary (
      .clk  (clk),
      .rst_n(rst_n),
      .stat (stat_q),
      .mask (mask_q),
      .clr  (irq_clr),
      .irq  (irq_latched)
   );

   always_comb begin
      if (sel_stat)      reg_rdata = stat_q;
      else if (sel_mask) reg_rdata = mask_q;
      else               reg_rdata = '0;
   end

   AST_RESUME_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (resume_seen && !suspended && !stat_q[B_RESUME]) |=> !stat_q[B_RESUME]); // R4

   AST_DIRERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ((tok_out_ep && ep_dir_in) || (tok_in_ep && !ep_dir_in)) |=> stat_q[B_DIRERR]); // R2

endmodule

// File: tb/test_usb_evt_flags.sv
`timescale 1ns/1ps
module test_usb_evt_flags;

   localparam logic [7:0] A_STAT = 8'h10;
   localparam logic [7:0] A_MASK = 8'h11;
   localparam logic [7:0] A_NONE = 8'h12;
   localparam logic [4:0] EV_NONE = 5'b00000;
   localparam logic [4:0] EV_TIN  = 5'b10000;
   localparam logic [4:0] EV_TOUT = 5'b01000;
   localparam logic [4:0] EV_HS   = 5'b00100;
   localparam logic [4:0] EV_RES  = 5'b00010;
   localparam logic [4:0] EV_BRST = 5'b00001;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       tok_in_ep = 1'b0, tok_out_ep = 1'b0, ep_dir_in = 1'b0;
   logic       hs_seen = 1'b0, resume_seen = 1'b0, bus_reset_seen = 1'b0;
   logic       suspended = 1'b0, err_pending = 1'b0, irq_clr = 1'b0;
   logic       irq_latched;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [7:0] rd;
      logic       irq;
      string      req;
   } item_t;
   item_t exp_q[$];

   always #10 clk = ~clk;

   usb_evt_flags i_usb_evt_flags (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tok_in_ep(tok_in_ep), .tok_out_ep(tok_out_ep), .ep_dir_in(ep_dir_in),
      .hs_seen(hs_seen), .resume_seen(resume_seen), .bus_reset_seen(bus_reset_seen),
      .suspended(suspended), .err_pending(err_pending), .irq_clr(irq_clr),
      .irq_latched(irq_latched)
   );

   // monitor: compares queued expectations a few ns after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         while (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            checks++;
            if (reg_rdata !== it.rd || irq_latched !== it.irq) begin
               errors++;
               $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                        it.req, reg_rdata, irq_latched, it.rd, it.irq);
            end
         end
      end
   end

   // one clock of stimulus, driven at edge+2ns, released at next edge+2ns
   task automatic step(input logic [4:0] ev, input logic wr, input logic [7:0] a,
                       input logic [7:0] d, input logic clr);
      {tok_in_ep, tok_out_ep, hs_seen, resume_seen, bus_reset_seen} = ev;
      reg_wr = wr; reg_addr = a; reg_wdata = d; irq_clr = clr;
      @(posedge clk); #2;
      {tok_in_ep, tok_out_ep, hs_seen, resume_seen, bus_reset_seen} = EV_NONE;
      reg_wr = 1'b0; irq_clr = 1'b0;
   endtask

   task automatic chk(input logic [7:0] a, input logic [7:0] rd, input logic irq,
                      input string req);
      item_t it;
      reg_addr = a;
      it.rd = rd; it.irq = irq; it.req = req;
      exp_q.push_back(it);
      @(posedge clk); #2;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      step(EV_NONE, 1'b1, a, d, 1'b0);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(posedge clk); #2;

      chk(A_STAT, 8'h00, 1'b0, "R1 flag reset");
      chk(A_MASK, 8'hFF, 1'b0, "R1 mask reset");

      // R2 wrong-direction tokens
      ep_dir_in = 1'b1;
      step(EV_TOUT, 1'b0, A_STAT, 8'h00, 1'b0);
      chk(A_STAT, 8'h40, 1'b0, "R2 OUT token to IN endpoint");
      wr(A_STAT, 8'h40);
      chk(A_STAT, 8'h00, 1'b0, "R6 clear dir flag");
      step(EV_TIN, 1'b0, A_STAT, 8'h00, 1'b0);
      chk(A_STAT, 8'h00, 1'b0, "R2 matching IN token");
      ep_dir_in = 1'b0;
      step(EV_TIN, 1'b0, A_STAT, 8'h00, 1'b0);
      chk(A_STAT, 8'h40, 1'b0, "R2 IN token to OUT endpoint");
      wr(A_STAT, 8'h40);

      // R3 / R6
      step(EV_HS, 1'b0, A_STAT, 8'h00, 1'b0);
      chk(A_STAT, 8'h20, 1'b0, "R3 high-speed flag");
      step(EV_BRST, 1'b0, A_STAT, 8'h00, 1'b0);
      chk(A_STAT, 8'h28, 1'b0, "R3 bus reset flag");
      wr(A_STAT, 8'h00);
      chk(A_STAT, 8'h28, 1'b0, "R6 write zero keeps flags");
      wr(A_STAT, 8'h08);
      chk(A_STAT, 8'h20, 1'b0, "R6 clear only bus reset");
      wr(A_STAT, 8'h20);
      chk(A_STAT, 8'h00, 1'b0, "R6 clear high-speed");

      // R4 resume gating
      suspended = 1'b0;
      step(EV_RES, 1'b0, A_STAT, 8'h00, 1'b0);
      chk(A_STAT, 8'h00, 1'b0, "R4 resume dropped when awake");
      suspended = 1'b1;
      step(EV_RES, 1'b0, A_STAT, 8'h00, 1'b0);
      chk(A_STAT, 8'h10, 1'b0, "R4 resume while suspended");
      wr(A_STAT, 8'h10);
      suspended = 1'b0;
      chk(A_STAT, 8'h00, 1'b0, "R6 clear resume");

      // R5 error mirror
      err_pending = 1'b1;
      chk(A_STAT, 8'h04, 1'b0, "R5 error mirror set");
      wr(A_STAT, 8'hFF);
      chk(A_STAT, 8'h04, 1'b0, "R5 error not write-clearable");
      err_pending = 1'b0;
      chk(A_STAT, 8'h00, 1'b0, "R5 error mirror clear");

      // R7 event beats clear
      step(EV_BRST, 1'b1, A_STAT, 8'h08, 1'b0);
      chk(A_STAT, 8'h08, 1'b0, "R7 event wins over clear");
      wr(A_STAT, 8'h08);

      // R8 reserved bits
      wr(A_MASK, 8'h00);
      chk(A_MASK, 8'h83, 1'b0, "R8 mask reserved ones");
      wr(A_MASK, 8'hFF);
      wr(A_STAT, 8'hFF);
      chk(A_STAT, 8'h00, 1'b0, "R8 flag reserved zeros");

      // R9 / R10 / R11
      step(EV_HS, 1'b0, A_STAT, 8'h00, 1'b0);
      chk(A_STAT, 8'h20, 1'b0, "R9 masked flag still sets");
      chk(A_STAT, 8'h20, 1'b0, "R9 masked flag no irq");
      wr(A_MASK, 8'hDF);
      chk(A_MASK, 8'hDF, 1'b0, "R10 irq not yet after unmask");
      chk(A_STAT, 8'h20, 1'b1, "R10 irq one edge later");
      wr(A_STAT, 8'h20);
      chk(A_STAT, 8'h00, 1'b1, "R11 irq held after flag clear");
      step(EV_NONE, 1'b0, A_STAT, 8'h00, 1'b1);
      chk(A_STAT, 8'h00, 1'b0, "R11 irq clear");
      step(EV_HS, 1'b0, A_STAT, 8'h00, 1'b0);
      chk(A_STAT, 8'h20, 1'b0, "R10 flag visible, irq pending");
      chk(A_STAT, 8'h20, 1'b1, "R10 irq set");
      step(EV_NONE, 1'b0, A_STAT, 8'h00, 1'b1);
      chk(A_STAT, 8'h20, 1'b1, "R11 clear ignored while live");
      wr(A_STAT, 8'h20);
      step(EV_NONE, 1'b0, A_STAT, 8'h00, 1'b1);
      chk(A_STAT, 8'h00, 1'b0, "R11 clear after flag gone");
      wr(A_MASK, 8'hFF);
      step(EV_BRST, 1'b0, A_STAT, 8'h00, 1'b0);
      chk(A_STAT, 8'h08, 1'b0, "R9 bus reset masked");
      chk(A_STAT, 8'h08, 1'b0, "R9 still no irq");
      wr(A_STAT, 8'h08);

      // R12 decode
      wr(A_NONE, 8'h00);
      chk(A_NONE, 8'h00, 1'b0, "R12 unused offset reads zero");
      chk(A_MASK, 8'hFF, 1'b0, "R12 unused write left mask");

      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule